// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This block performs trap entry for a single-hart 32-bit core that runs at machine privilege. At each instruction boundary the core raises `step_i` and presents the current program counter and privilege level. Alongside these it presents any pending synchronous exception and any pending interrupt. When a trap is accepted, the block sends the core to the handler through `next_pc_o`. It sets `next_mode_o` to machine level and records the trap state in its machine CSRs on the following clock edge.

The block holds the trap vector base, the saved exception PC, the cause, the trap value and the interrupt-enable stack of the status register. A plain CSR port lets the core read and write these registers. The same port reads the fixed identification registers. The port uses the standard machine CSR addresses: status 0x300, ISA 0x301, vector 0x305, exception PC 0x341, cause 0x342, trap value 0x343, implementation id 0xF13 and hart id 0xF14. Instruction decode, trap return and memory access belong to the core.

Top module: `mtrap_entry`

## Requirements
- R1: After reset, the status, vector, exception PC, cause and trap value registers all read 0, and no trap is signalled.
- R2: After a trap, the cause register reads the interrupt flag in bit 31 and the 31-bit code in bits 30:0.
- R3: After a trap, the exception PC register holds the `cur_pc_i` of the trapping step. The trap value register holds `exc_tval_i` for an exception and 0 for an interrupt.
- R4: After a trap, the status register has its previous-privilege field (bits 12:11) equal to the trapping `cur_mode_i`. Its previous-enable bit (bit 7) equals the old enable bit, and its enable bit (bit 3) is 0.
- R5: While a trap is taken, `trap_taken_o` is 1 and `next_mode_o` is 3 (machine). Otherwise `next_mode_o` equals `cur_mode_i` and `next_pc_o` equals `cur_pc_i + 4`.
- R6: The handler base is the vector register with bits 1:0 cleared. An interrupt taken while vector bits 1:0 equal 1 goes to base + 4 × code. Every other trap goes to base.
- R7: The ISA register reads 0x40001100, and the hart id and implementation id registers read 0. Writes to these three registers change nothing.
- R8: Pending requests are acted on only in a cycle where `step_i` is 1. With `step_i` at 0 there is no trap and no register change.
- R9: An exception is taken whatever the enable bit holds. An interrupt is taken only while status bit 3 is 1.
- R10: When an exception and an enabled interrupt arrive in the same step, the exception is taken and its code goes to the cause register.
- R11: A status write stores only bits 3, 7 and 12:11, and the other bits read 0. A trap in the same cycle as a CSR write to a trap-updated register overrides that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Instruction boundary; requests are checked in this cycle |
| cur_pc_i | input | 32 | PC of the instruction at this boundary |
| cur_mode_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| exc_valid_i | input | 1 | Synchronous exception pending |
| exc_code_i | input | 31 | Exception code |
| exc_tval_i | input | 32 | Exception trap value |
| irq_valid_i | input | 1 | Interrupt pending |
| irq_code_i | input | 31 | Interrupt code |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data at `csr_addr_i` (combinational) |
| trap_taken_o | output | 1 | A trap is accepted this cycle |
| next_pc_o | output | 32 | PC for the next fetch |
| next_mode_o | output | 2 | Privilege level after this boundary |

## Verification
The hardest case to reach is a single step that carries both an exception and an interrupt while the enable bit is set. The enable bit is cleared by every trap, so the stimulus first restores it through a status write and then raises both requests in the same cycle. A second hard case is a trap that lands in the same cycle as a CSR write to the exception PC, which shows whether the trap overrides the write. Vectored dispatch is checked with an interrupt and then with an exception under the same vector setting, so the two address rules can be told apart.

// File: rtl/mtrap_pkg.sv
// Shared constants and types for the machine-mode trap entry unit.
// Assumes a 32-bit hart; the CSR addresses are the standard machine ones.
package mtrap_pkg;

    localparam int XLEN   = 32;
    localparam int CODE_W = XLEN - 1;
    localparam int ADDR_W = 12;

    // privilege levels
    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    // CSR addresses decoded by the neighbouring core
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h300;
    localparam logic [ADDR_W-1:0] A_ISA    = 12'h301;
    localparam logic [ADDR_W-1:0] A_VECTOR = 12'h305;
    localparam logic [ADDR_W-1:0] A_EPC    = 12'h341;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 12'h342;
    localparam logic [ADDR_W-1:0] A_TVAL   = 12'h343;
    localparam logic [ADDR_W-1:0] A_IMPID  = 12'hF13;
    localparam logic [ADDR_W-1:0] A_HARTID = 12'hF14;

    // status field positions
    localparam int ST_IE_BIT   = 3;
    localparam int ST_PIE_BIT  = 7;
    localparam int ST_PP_LO    = 11;

    // vector mode encodings
    localparam logic [1:0] VEC_DIRECT   = 2'd0;
    localparam logic [1:0] VEC_VECTORED = 2'd1;

    // one accepted trap
    typedef struct packed {
        logic              irq;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   tval;
    } trap_req_t;

    // ISA word: 32-bit width field plus base-integer and multiply letters
    function automatic logic [XLEN-1:0] isa_word();
        logic [XLEN-1:0] w;
        w = '0;
        w[XLEN-1:XLEN-2] = 2'b01;
        w[8]  = 1'b1;
        w[12] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/mtrap_select.sv
// Trap selection: picks which pending request, if any, is accepted at an
// instruction boundary. Exceptions beat interrupts; interrupts need the
// global enable. Purely combinational; clk/rst_n only clock the checks.
module mtrap_select
    import mtrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_tval,
    input  logic              irq_valid,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              irq_enable,
    output logic              take,
    output trap_req_t         req
);

    logic exc_go;
    logic irq_go;

    // qualify each source with the step strobe and, for interrupts, the enable
    always_comb begin
        exc_go = step && exc_valid;
        irq_go = step && irq_valid && irq_enable;
    end

    // priority mux: exception first, interrupt second
    always_comb begin
        take     = exc_go || irq_go;
        req      = '0;
        if (exc_go) begin
            req.irq  = 1'b0;
            req.code = exc_code;
            req.tval = exc_tval;
        end else if (irq_go) begin
            req.irq  = 1'b1;
            req.code = irq_code;
            req.tval = '0;
        end
    end

    p_no_trap_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> !take);
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req.irq) |-> irq_enable);
    p_exc_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && exc_valid) |-> (take && !req.irq && req.code == exc_code));

endmodule

// File: rtl/mtrap_vector.sv
// Redirect computation: next PC and privilege level for this boundary.
// Assumes 4-byte instructions (STRIDE_LOG2 = 2) and a handler table that
// is entered only by interrupts in vectored mode.
module mtrap_vector
    import mtrap_pkg::*;
#(
    parameter int STRIDE_LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  trap_req_t       req,
    input  logic [XLEN-1:0] vector,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [1:0]      cur_mode,
    output logic [XLEN-1:0] next_pc,
    output logic [1:0]      next_mode
);

    localparam int INSN_BYTES = 1 << STRIDE_LOG2;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] slot_off;
    logic            use_table;

    // base address and table slot offset
    always_comb begin
        base      = {vector[XLEN-1:2], 2'b00};
        slot_off  = XLEN'(req.code) << STRIDE_LOG2;
        use_table = req.irq && (vector[1:0] == VEC_VECTORED);
    end

    // select sequential, direct or table target
    always_comb begin
        if (!take) begin
            next_pc   = cur_pc + XLEN'(INSN_BYTES);
            next_mode = cur_mode;
        end else begin
            next_pc   = use_table ? base + slot_off : base;
            next_mode = PRIV_MACH;
        end
    end

    p_mode_mach_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> next_mode == 2'd3);
    p_target_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> next_pc[1:0] == 2'b00);
    p_sequential_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (next_mode == cur_mode));

endmodule

// File: rtl/mtrap_csr.sv
// Machine CSR storage for trap entry: status enable stack, vector,
// exception PC, cause and trap value, plus fixed identification reads.
// A trap in the same cycle as a CSR write wins on every register the
// trap updates. Reads are combinational on the address.
module mtrap_csr
    import mtrap_pkg::*;
#(
    parameter logic [XLEN-1:0] HART_ID = '0,
    parameter logic [XLEN-1:0] IMP_ID  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  trap_req_t         req,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   rdata,
    output logic              irq_enable,
    output logic [XLEN-1:0]   vector
);

    logic            st_ie;
    logic            st_pie;
    logic [1:0]      st_pp;
    logic [XLEN-1:0] epc_q;
    logic            cause_irq_q;
    logic [CODE_W-1:0] cause_code_q;
    logic [XLEN-1:0] tval_q;
    logic [XLEN-1:0] vector_q;
    logic [XLEN-1:0] status_view;

    logic wr_status;
    logic wr_vector;
    logic wr_epc;
    logic wr_cause;
    logic wr_tval;

    // write decode
    always_comb begin
        wr_status = wr_en && (addr == A_STATUS);
        wr_vector = wr_en && (addr == A_VECTOR);
        wr_epc    = wr_en && (addr == A_EPC);
        wr_cause  = wr_en && (addr == A_CAUSE);
        wr_tval   = wr_en && (addr == A_TVAL);
    end

    // status enable stack: trap push overrides software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_ie  <= 1'b0;
            st_pie <= 1'b0;
            st_pp  <= 2'd0;
        end else if (take) begin
            st_pp  <= cur_mode;
            st_pie <= st_ie;
            st_ie  <= 1'b0;
        end else if (wr_status) begin
            st_ie  <= wdata[ST_IE_BIT];
            st_pie <= wdata[ST_PIE_BIT];
            st_pp  <= wdata[ST_PP_LO+1:ST_PP_LO];
        end
    end

    // trap record registers: exception PC, cause, trap value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q        <= '0;
            cause_irq_q  <= 1'b0;
            cause_code_q <= '0;
            tval_q       <= '0;
        end else if (take) begin
            epc_q        <= cur_pc;
            cause_irq_q  <= req.irq;
            cause_code_q <= req.code;
            tval_q       <= req.tval;
        end else begin
            if (wr_epc) begin
                epc_q <= wdata;
            end
            if (wr_cause) begin
                cause_irq_q  <= wdata[XLEN-1];
                cause_code_q <= wdata[CODE_W-1:0];
            end
            if (wr_tval) begin
                tval_q <= wdata;
            end
        end
    end

    // vector register: written only by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector_q <= '0;
        end else if (wr_vector) begin
            vector_q <= wdata;
        end
    end

    // assemble the architectural status word
    always_comb begin
        status_view = '0;
        status_view[ST_IE_BIT]            = st_ie;
        status_view[ST_PIE_BIT]           = st_pie;
        status_view[ST_PP_LO+1:ST_PP_LO]  = st_pp;
    end

    // read mux
    always_comb begin
        unique case (addr)
            A_STATUS: rdata = status_view;
            A_ISA:    rdata = isa_word();
            A_VECTOR: rdata = vector_q;
            A_EPC:    rdata = epc_q;
            A_CAUSE:  rdata = {cause_irq_q, cause_code_q};
            A_TVAL:   rdata = tval_q;
            A_IMPID:  rdata = IMP_ID;
            A_HARTID: rdata = HART_ID;
            default:  rdata = '0;
        endcase
    end

    // exported state
    always_comb begin
        irq_enable = st_ie;
        vector     = vector_q;
    end

    p_epc_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> epc_q == $past(cur_pc));
    p_cause_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> {cause_irq_q, cause_code_q} == {$past(req.irq), $past(req.code)});
    p_ie_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !st_ie);
    p_pie_saved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> st_pie == $past(st_ie));
    p_pp_saved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> st_pp == $past(cur_mode));
    p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !wr_en) |=> $stable(epc_q) && $stable(tval_q) && $stable(st_ie));

endmodule

// File: rtl/mtrap_entry.sv
// Top of the machine-mode trap entry unit. Wires trap selection, redirect
// computation and the machine CSR storage. The core presents one
// instruction boundary per step_i pulse and follows next_pc_o/next_mode_o.
module mtrap_entry
    import mtrap_pkg::*;
#(
    parameter int          STRIDE_LOG2 = 2,
    parameter logic [31:0] HART_ID     = 32'd0,
    parameter logic [31:0] IMP_ID      = 32'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    input  logic [31:0] cur_pc_i,
    input  logic [1:0]  cur_mode_i,
    input  logic        exc_valid_i,
    input  logic [30:0] exc_code_i,
    input  logic [31:0] exc_tval_i,
    input  logic        irq_valid_i,
    input  logic [30:0] irq_code_i,
    input  logic        csr_we_i,
    input  logic [11:0] csr_addr_i,
    input  logic [31:0] csr_wdata_i,
    output logic [31:0] csr_rdata_o,
    output logic        trap_taken_o,
    output logic [31:0] next_pc_o,
    output logic [1:0]  next_mode_o
);

    logic            take;
    trap_req_t       req;
    logic            irq_enable;
    logic [XLEN-1:0] vector;

    mtrap_select u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step_i),
        .exc_valid  (exc_valid_i),
        .exc_code   (exc_code_i),
        .exc_tval   (exc_tval_i),
        .irq_valid  (irq_valid_i),
        .irq_code   (irq_code_i),
        .irq_enable (irq_enable),
        .take       (take),
        .req        (req)
    );

    mtrap_vector #(
        .STRIDE_LOG2 (STRIDE_LOG2)
    ) u_vector (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .req       (req),
        .vector    (vector),
        .cur_pc    (cur_pc_i),
        .cur_mode  (cur_mode_i),
        .next_pc   (next_pc_o),
        .next_mode (next_mode_o)
    );

    mtrap_csr #(
        .HART_ID (HART_ID),
        .IMP_ID  (IMP_ID)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .req        (req),
        .cur_pc     (cur_pc_i),
        .cur_mode   (cur_mode_i),
        .wr_en      (csr_we_i),
        .addr       (csr_addr_i),
        .wdata      (csr_wdata_i),
        .rdata      (csr_rdata_o),
        .irq_enable (irq_enable),
        .vector     (vector)
    );

    // drive the trap strobe out
    always_comb trap_taken_o = take;

    p_taken_needs_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken_o |-> step_i);
    p_masked_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && irq_valid_i && !exc_valid_i && !irq_enable) |-> !trap_taken_o);

endmodule

// File: tb/tb_mtrap_entry.sv
module tb_mtrap_entry;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_i;
    logic [31:0] cur_pc_i;
    logic [1:0]  cur_mode_i;
    logic        exc_valid_i;
    logic [30:0] exc_code_i;
    logic [31:0] exc_tval_i;
    logic        irq_valid_i;
    logic [30:0] irq_code_i;
    logic        csr_we_i;
    logic [11:0] csr_addr_i;
    logic [31:0] csr_wdata_i;
    logic [31:0] csr_rdata_o;
    logic        trap_taken_o;
    logic [31:0] next_pc_o;
    logic [1:0]  next_mode_o;

    mtrap_entry dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // scoreboard queues: observed output kind, expected value, requirement
    int    q_kind[$];
    logic [31:0] q_exp[$];
    string q_req[$];

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // bench model of CSR state
    logic        m_ie, m_pie;
    logic [1:0]  m_pp;
    logic [31:0] m_vec, m_epc, m_cause, m_tval;

    function automatic logic [31:0] m_status();
        return {19'd0, m_pp, 3'd0, m_pie, 3'd0, m_ie, 3'd0};
    endfunction

    task automatic expect_out(input int kind, input logic [31:0] v, input string rq);
        q_kind.push_back(kind);
        q_exp.push_back(v);
        q_req.push_back(rq);
    endtask

    // drive every input for one cycle, starting at a falling edge
    task automatic cyc(input logic st, input logic [31:0] pc, input logic [1:0] md,
                       input logic ev, input logic [30:0] ec, input logic [31:0] et,
                       input logic iv, input logic [30:0] ic,
                       input logic we, input logic [11:0] wa, input logic [31:0] wd);
        @(negedge clk);
        step_i = st; cur_pc_i = pc; cur_mode_i = md;
        exc_valid_i = ev; exc_code_i = ec; exc_tval_i = et;
        irq_valid_i = iv; irq_code_i = ic;
        csr_we_i = we; csr_addr_i = wa; csr_wdata_i = wd;
    endtask

    // model effect of a software write
    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h300: begin m_ie = d[3]; m_pie = d[7]; m_pp = d[12:11]; end
            12'h305: m_vec = d;
            12'h341: m_epc = d;
            12'h342: m_cause = d;
            12'h343: m_tval = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string rq);
        cyc(1'b0, 32'h0, 2'd0, 1'b0, 31'd0, 32'd0, 1'b0, 31'd0, 1'b0, a, 32'd0);
        expect_out(0, e, rq);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b0, 32'h0, 2'd0, 1'b0, 31'd0, 32'd0, 1'b0, 31'd0, 1'b1, a, d);
        model_write(a, d);
    endtask

    // one boundary with requests; expectations from the requirements
    task automatic stepc(input logic st, input logic [31:0] pc, input logic [1:0] md,
                         input logic ev, input logic [30:0] ec, input logic [31:0] et,
                         input logic iv, input logic [30:0] ic,
                         input logic we, input logic [11:0] wa, input logic [31:0] wd,
                         input string rq);
        logic        tk, is_irq;
        logic [30:0] code;
        logic [31:0] base, epc;
        cyc(st, pc, md, ev, ec, et, iv, ic, we, wa, wd);
        tk     = st && (ev || (iv && m_ie));
        is_irq = !ev;
        code   = ev ? ec : ic;
        base   = {m_vec[31:2], 2'b00};
        if (!tk) epc = pc + 32'd4;
        else if (is_irq && m_vec[1:0] == 2'd1) epc = base + {code[29:0], 2'b00};
        else epc = base;
        expect_out(3, {31'd0, tk}, rq);
        expect_out(1, epc, rq);
        expect_out(2, {30'd0, tk ? 2'd3 : md}, rq);
        if (we) model_write(wa, wd);
        if (tk) begin
            m_epc   = pc;
            m_cause = {is_irq, code};
            m_tval  = is_irq ? 32'd0 : et;
            m_pp    = md;
            m_pie   = m_ie;
            m_ie    = 1'b0;
        end
    endtask

    // monitor: pops and compares shortly after each falling edge
    initial begin
        int          k;
        logic [31:0] e, g;
        string       r;
        forever begin
            @(negedge clk);
            #2;
            while (q_kind.size() > 0) begin
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                r = q_req.pop_front();
                case (k)
                    0:       g = csr_rdata_o;
                    1:       g = next_pc_o;
                    2:       g = {30'd0, next_mode_o};
                    default: g = {31'd0, trap_taken_o};
                endcase
                n_checks++;
                if (g !== e) begin
                    n_fails++;
                    $display("FAIL %s kind=%0d actual=%08h expected=%08h", r, k, g, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        m_ie = 0; m_pie = 0; m_pp = 0;
        m_vec = 0; m_epc = 0; m_cause = 0; m_tval = 0;
        rst_n = 1'b0;
        step_i = 0; cur_pc_i = 0; cur_mode_i = 0;
        exc_valid_i = 0; exc_code_i = 0; exc_tval_i = 0;
        irq_valid_i = 0; irq_code_i = 0;
        csr_we_i = 0; csr_addr_i = 0; csr_wdata_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h300, 32'd0, "R1");
        rd(12'h305, 32'd0, "R1");
        rd(12'h341, 32'd0, "R1");
        rd(12'h342, 32'd0, "R1");
        rd(12'h343, 32'd0, "R1");
        stepc(1'b0, 32'h100, 2'd0, 1'b0, 31'd0, 32'd0, 1'b0, 31'd0, 1'b0, 12'h0, 32'd0, "R1");

        // R7 identification registers, writes ignored
        rd(12'h301, 32'h4000_1100, "R7");
        rd(12'hF14, 32'd0, "R7");
        rd(12'hF13, 32'd0, "R7");
        wr(12'h301, 32'hFFFF_FFFF);
        wr(12'hF14, 32'h1234_5678);
        rd(12'h301, 32'h4000_1100, "R7");
        rd(12'hF14, 32'd0, "R7");

        // R6 direct mode exception, R5 redirect
        wr(12'h305, 32'h0000_1000);
        stepc(1'b1, 32'h200, 2'd0, 1'b1, 31'd2, 32'hDEAD_BEEF, 1'b0, 31'd0, 1'b0, 12'h0, 32'd0, "R5_R6");
        rd(12'h341, 32'h200, "R3");
        rd(12'h343, 32'hDEAD_BEEF, "R3");
        rd(12'h342, 32'h2, "R2");
        rd(12'h300, m_status(), "R4");

        // R11 status write masking
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h300, 32'h0000_1888, "R11");
        wr(12'h300, 32'h0);

        // R9 masked interrupt: no trap, sequential redirect
        stepc(1'b1, 32'h240, 2'd1, 1'b0, 31'd0, 32'd0, 1'b1, 31'd7, 1'b0, 12'h0, 32'd0, "R9");
        rd(12'h342, 32'h2, "R9");

        // R6 vectored interrupt
        wr(12'h305, 32'h0000_2001);
        wr(12'h300, 32'h0000_0008);
        stepc(1'b1, 32'h300, 2'd3, 1'b0, 31'd0, 32'd0, 1'b1, 31'd7, 1'b0, 12'h0, 32'd0, "R6");
        rd(12'h342, 32'h8000_0007, "R2");
        rd(12'h343, 32'd0, "R3");
        rd(12'h300, 32'h0000_1880, "R4");

        // R6 exception in vectored mode goes to base; R9 exception with enable 0
        stepc(1'b1, 32'h340, 2'd1, 1'b1, 31'd5, 32'h55, 1'b0, 31'd0, 1'b0, 12'h0, 32'd0, "R6_R9");
        rd(12'h300, 32'h0000_0800, "R4");

        // R8 no step: request ignored
        stepc(1'b0, 32'h380, 2'd0, 1'b1, 31'd9, 32'h99, 1'b1, 31'd3, 1'b0, 12'h0, 32'd0, "R8");
        rd(12'h341, 32'h340, "R8");
        rd(12'h343, 32'h55, "R8");

        // R10 simultaneous exception and enabled interrupt
        wr(12'h300, 32'h0000_0008);
        stepc(1'b1, 32'h3C0, 2'd0, 1'b1, 31'd4, 32'h44, 1'b1, 31'd3, 1'b0, 12'h0, 32'd0, "R10");
        rd(12'h342, 32'h4, "R10");

        // R11 trap overrides same-cycle write of exception PC
        stepc(1'b1, 32'h400, 2'd0, 1'b1, 31'd1, 32'h11, 1'b0, 31'd0, 1'b1, 12'h341, 32'h1234, "R11");
        rd(12'h341, 32'h400, "R11");

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule